// File: doc/BRIEF.md
# Selectable Wait-Event Combiner

A small sequencer core can stall on a hardware condition instead of polling for it. This block builds that condition. It takes a wide event bus and two source indices, picks one or two event lines, and forms a single registered condition bit. With combining switched on, the two picked lines are ORed, each after an optional inversion. A typical use is a wait that ends on a data condition or on a timeout tick, whichever comes first.

The settings live in two configuration words. A simple write port fills them and a combinational read port returns them. The block also emits a one-cycle release pulse for a core that holds its wait-request line high. The pulse fires in the first cycle the registered condition is true during that request.

Top module: `wev_combiner`

## Requirements
- R1: Each of the two source selects is a SEL_W-bit index (6 bits for the default 64-line bus). It picks event line `ev_bus[index]`.
- R2: With the combine bit at 0, the condition equals the line picked by select A, never inverted. Select B and both polarity bits have no effect on it.
- R3: With the combine bit at 1, the condition is `(ev_bus[selA] ^ polA) | (ev_bus[selB] ^ polB)`.
- R4: `cond_q` is registered once. It reflects the bus and configuration sampled at the previous rising clock edge. A configuration write and a bus change in the same cycle therefore produce one output computed with the old configuration and the new bus.
- R5: After reset every configuration field is 0, and `cond_q` and `release_o` are 0.
- R6: `release_o` is high for exactly one cycle. It rises in the first cycle where `cond_q` and `wait_req` are both high. It fires again only after `wait_req` has been low for at least one clock edge.
- R7: Word 0 holds select A in bits [5:0] and the combine bit in bit 6. Word 1 holds select B in bits [5:0], polarity A in bit 6 and polarity B in bit 7. A write stores those fields. A read of either word returns them, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 1 | Word select for the write (0 or 1) |
| cfg_wdata | input | DATA_W | Write data |
| cfg_raddr | input | 1 | Word select for the read |
| cfg_rdata | output | DATA_W | Read data, reserved bits 0 |
| ev_bus | input | EV_W | Event bus, already synchronised |
| wait_req | input | 1 | High while the core is stalled waiting |
| cond_q | output | 1 | Registered combined condition |
| release_o | output | 1 | One-cycle wait-release pulse |

## Verification
A configuration write and an event-bus change can land in the same cycle. The bench drives both at once: it moves select A to a new line while the old line drops and the new one rises. It then expects `cond_q` to follow the old select with the new bus for one cycle, and the new select after that. A second overlap is a release that coincides with `wait_req` being dropped and re-raised while the condition stays true. Here the bench expects exactly one pulse per request.

// File: rtl/wev_pkg.sv
package wev_pkg;

   typedef enum logic {
      WORD_MODE = 1'b0,
      WORD_AUX  = 1'b1
   } wev_word_e;

   function automatic logic wev_apply_pol(input logic ev, input logic pol, input logic comb);
      return ev ^ (pol & comb);
   endfunction

endpackage

// File: rtl/wev_cfg_regs.sv
module wev_cfg_regs
   import wev_pkg::*;
#(
   parameter int SEL_W  = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [SEL_W-1:0]  sel_a,
   output logic [SEL_W-1:0]  sel_b,
   output logic              comb,
   output logic              pol_a,
   output logic              pol_b
);
   localparam int COMB_BIT = SEL_W;
   localparam int POLA_BIT = SEL_W;
   localparam int POLB_BIT = SEL_W + 1;

   if (DATA_W < SEL_W + 2) begin : g_bad_data_w
      $error("wev_cfg_regs: DATA_W too small for the configuration fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_a <= '0;
         comb  <= 1'b0;
         sel_b <= '0;
         pol_a <= 1'b0;
         pol_b <= 1'b0;
      end else if (we) begin
         if (wev_word_e'(waddr) == WORD_MODE) begin
            sel_a <= wdata[SEL_W-1:0];
            comb  <= wdata[COMB_BIT];
         end else begin
            sel_b <= wdata[SEL_W-1:0];
            pol_a <= wdata[POLA_BIT];
            pol_b <= wdata[POLB_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (wev_word_e'(raddr) == WORD_MODE) begin
         rdata[SEL_W-1:0] = sel_a;
         rdata[COMB_BIT]  = comb;
      end else begin
         rdata[SEL_W-1:0] = sel_b;
         rdata[POLA_BIT]  = pol_a;
         rdata[POLB_BIT]  = pol_b;
      end
   end
endmodule

// File: rtl/wev_src_path.sv
module wev_src_path
   import wev_pkg::*;
#(
   parameter int EV_W  = 64,
   parameter int SEL_W = 6
) (
   input  logic [EV_W-1:0]  ev_bus,
   input  logic [SEL_W-1:0] sel,
   input  logic             pol,
   input  logic             comb,
   output logic             ev
);
   if (EV_W != (1 << SEL_W)) begin : g_bad_sel_w
      $error("wev_src_path: EV_W must equal 2**SEL_W");
   end

   always_comb ev = wev_apply_pol(ev_bus[sel], pol, comb);
endmodule

// File: rtl/wev_release.sv
module wev_release (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_req,
   input  logic cond,
   output logic pulse
);
   logic held_q;

   assign pulse = wait_req & cond & ~held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_q <= 1'b0;
      else if (!wait_req) held_q <= 1'b0;
      else if (pulse)     held_q <= 1'b1;
   end
endmodule

// File: rtl/wev_combiner.sv
module wev_combiner
   import wev_pkg::*;
#(
   parameter int EV_W   = 64,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_waddr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_raddr,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [EV_W-1:0]   ev_bus,
   input  logic              wait_req,
   output logic              cond_q,
   output logic              release_o
);
   localparam int SEL_W = $clog2(EV_W);
   localparam int N_SRC = 2;

   if (EV_W < 2) begin : g_bad_ev_w
      $error("wev_combiner: EV_W must be at least 2");
   end

   logic [SEL_W-1:0] sel_a, sel_b;
   logic             comb, pol_a, pol_b;
   logic [SEL_W-1:0] src_sel [N_SRC];
   logic [N_SRC-1:0] src_pol;
   logic [N_SRC-1:0] src_ev;
   logic             cond_d;

   wev_cfg_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .waddr (cfg_waddr),
      .wdata (cfg_wdata),
      .raddr (cfg_raddr),
      .rdata (cfg_rdata),
      .sel_a (sel_a),
      .sel_b (sel_b),
      .comb  (comb),
      .pol_a (pol_a),
      .pol_b (pol_b)
   );

   assign src_sel[0] = sel_a;
   assign src_sel[1] = sel_b;
   assign src_pol    = {pol_b, pol_a};

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      wev_src_path #(.EV_W(EV_W), .SEL_W(SEL_W)) u_path (
         .ev_bus (ev_bus),
         .sel    (src_sel[i]),
         .pol    (src_pol[i]),
         .comb   (comb),
         .ev     (src_ev[i])
      );
   end

   always_comb cond_d = comb ? (|src_ev) : src_ev[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond_d;
   end

   wev_release u_rel (
      .clk      (clk),
      .rst_n    (rst_n),
      .wait_req (wait_req),
      .cond     (cond_q),
      .pulse    (release_o)
   );
endmodule

// File: rtl/wev_combiner_chk.sv
module wev_combiner_chk #(
   parameter int EV_W   = 64,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [EV_W-1:0]   ev_bus,
   input logic [SEL_W-1:0]  sel_a,
   input logic [SEL_W-1:0]  sel_b,
   input logic              comb,
   input logic              pol_a,
   input logic              pol_b,
   input logic              wait_req,
   input logic              cond_q,
   input logic              release_o,
   input logic              cfg_raddr,
   input logic [DATA_W-1:0] cfg_rdata
);
   a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      !comb |=> (cond_q == $past(ev_bus[sel_a])));

   a_r3_combine: assert property (@(posedge clk) disable iff (!rst_n)
      comb |=> (cond_q == $past((ev_bus[sel_a] ^ pol_a) | (ev_bus[sel_b] ^ pol_b))));

   a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |=> !release_o);

   a_r6_needs_wait_and_cond: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |-> (wait_req && cond_q));

   a_r7_mode_word_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_raddr == 1'b0) |-> !cfg_rdata[SEL_W+1]);

   if (DATA_W > SEL_W + 2) begin : g_upper
      a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_rdata[DATA_W-1:SEL_W+2] == '0);
   end
endmodule

bind wev_combiner wev_combiner_chk #(.EV_W(EV_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_bus    (ev_bus),
   .sel_a     (sel_a),
   .sel_b     (sel_b),
   .comb      (comb),
   .pol_a     (pol_a),
   .pol_b     (pol_b),
   .wait_req  (wait_req),
   .cond_q    (cond_q),
   .release_o (release_o),
   .cfg_raddr (cfg_raddr),
   .cfg_rdata (cfg_rdata)
);

// File: tb/wev_combiner_tb.sv
`timescale 1ns/1ps
module wev_combiner_tb;
   localparam int EV_W   = 64;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic              cfg_waddr = 1'b0;
   logic [DATA_W-1:0] cfg_wdata = '0;
   logic              cfg_raddr = 1'b0;
   logic [DATA_W-1:0] cfg_rdata;
   logic [EV_W-1:0]   ev_bus = '0;
   logic              wait_req = 1'b0;
   logic              cond_q;
   logic              release_o;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   wev_combiner #(.EV_W(EV_W), .DATA_W(DATA_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_waddr (cfg_waddr),
      .cfg_wdata (cfg_wdata),
      .cfg_raddr (cfg_raddr),
      .cfg_rdata (cfg_rdata),
      .ev_bus    (ev_bus),
      .wait_req  (wait_req),
      .cond_q    (cond_q),
      .release_o (release_o)
   );

   task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] mode_word(input int sa, input logic cb);
      logic [DATA_W-1:0] w = '0;
      w[5:0] = 6'(sa);
      w[6]   = cb;
      return w;
   endfunction

   function automatic logic [DATA_W-1:0] aux_word(input int sb, input logic pa, input logic pb);
      logic [DATA_W-1:0] w = '0;
      w[5:0] = 6'(sb);
      w[6]   = pa;
      w[7]   = pb;
      return w;
   endfunction

   task automatic write_cfg(input logic a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '1;
   endtask

   task automatic read_chk(input string req, input logic a, input logic [DATA_W-1:0] exp);
      cfg_raddr = a;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R5 reset state
      check("R5 cond", {31'd0, cond_q}, 0);
      check("R5 release", {31'd0, release_o}, 0);
      read_chk("R5 word0", 1'b0, 0);
      read_chk("R5 word1", 1'b1, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R3 R7 sweep: every select A, eight mode/polarity combos, four bus patterns
      for (int sa = 0; sa < EV_W; sa++) begin
         for (int m = 0; m < 8; m++) begin
            int  sb;
            logic cb, pa, pb;
            sb = (sa * 7 + 3) % EV_W;
            cb = m[0]; pa = m[1]; pb = m[2];
            write_cfg(1'b0, mode_word(sa, cb));
            write_cfg(1'b1, aux_word(sb, pa, pb));
            read_chk("R7 word0 readback", 1'b0, mode_word(sa, cb));
            read_chk("R7 word1 readback", 1'b1, aux_word(sb, pa, pb));
            for (int p = 0; p < 4; p++) begin
               logic ea, eb, exp;
               ea = p[0]; eb = p[1];
               ev_bus = '0;
               ev_bus[sa] = ea;
               ev_bus[sb] = eb;
               exp = cb ? ((ea ^ pa) | (eb ^ pb)) : ea;
               @(negedge clk);
               check(cb ? "R3 combine" : "R2 pass-through", {31'd0, cond_q}, {31'd0, exp});
            end
         end
      end

      // R4: write and bus change in the same cycle
      write_cfg(1'b1, aux_word(0, 1'b0, 1'b0));
      write_cfg(1'b0, mode_word(10, 1'b0));
      ev_bus = '0; ev_bus[10] = 1'b1;
      @(negedge clk);
      check("R4 settle", {31'd0, cond_q}, 1);
      cfg_we = 1'b1; cfg_waddr = 1'b0; cfg_wdata = mode_word(20, 1'b0);
      ev_bus = '0; ev_bus[20] = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R4 old select new bus", {31'd0, cond_q}, 0);
      @(negedge clk);
      check("R4 new select", {31'd0, cond_q}, 1);

      // R6 release pulse
      ev_bus = '0;
      write_cfg(1'b0, mode_word(5, 1'b0));
      wait_req = 1'b1;
      @(negedge clk);
      check("R6 no release without cond", {31'd0, release_o}, 0);
      ev_bus[5] = 1'b1;
      @(negedge clk);
      #1;
      check("R6 release fires", {31'd0, release_o}, 1);
      @(negedge clk);
      #1;
      check("R6 one cycle only", {31'd0, release_o}, 0);
      wait_req = 1'b0;
      #1;
      check("R6 wait low", {31'd0, release_o}, 0);
      @(negedge clk);
      wait_req = 1'b1;
      #1;
      check("R6 re-armed", {31'd0, release_o}, 1);
      @(negedge clk);
      #1;
      check("R6 re-armed single", {31'd0, release_o}, 0);
      wait_req = 1'b0;

      // R7 reserved bits of write data are not stored
      write_cfg(1'b0, '1);
      read_chk("R7 reserved word0", 1'b0, mode_word(63, 1'b1));
      write_cfg(1'b1, '1);
      read_chk("R7 reserved word1", 1'b1, aux_word(63, 1'b1, 1'b1));

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule